// File: doc/BRIEF.md
# Set/Clear GPIO Register Block

This block is a register-addressed controller for up to 32 general-purpose pins on a 64-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data. Each pin owns a configuration word holding an output enable, an input inversion bit, an interrupt enable and a 5-bit output-source code. Pins with an index below a parameterized boundary keep their configuration words in a low window. Pins at or above the boundary use a second window.

Pin levels pass through a two-flop synchronizer. They are then optionally inverted and captured into an input data register. Output levels live in one shared register. Software never rewrites that register directly: one offset raises the selected bits and a second offset lowers them, so concurrent agents cannot lose each other's updates. A pin drives either its output register bit or one of 31 alternate signals presented on a plain input bus. A pin with its interrupt enable set gives a one-cycle pending pulse on each change of its synchronized level.

Top module: `gpio_setclr`

## Requirements
- R1: After reset every configuration word reads 0, the output register reads 0, every `pin_oe` and `pin_out` bit is 0, `irq_pend` is 0 and the input data register reads 0 while the pins are low.
- R2: The configuration word of pin n below `EXT_BASE` sits at byte offset 8*n. A pin n at or above `EXT_BASE` sits at 0x100 + 8*(n - `EXT_BASE`). In that word bit 0 is output enable, bit 1 is input inversion, bit 2 is interrupt enable and bits 20:16 are the output-source code. All other bits read 0.
- R3: A pin at or above `EXT_BASE` has no interrupt-enable storage: bit 2 of its word always reads 0 and writing a 1 there has no effect on the word or on `irq_pend`.
- R4: A write to offset 0x088 sets every output register bit whose data bit is 1 and leaves the others unchanged. Data bits at or above `NUM_PINS` are ignored. Reads of 0x088 and of 0x090 both return the output register in bits `NUM_PINS`-1:0.
- R5: A write to offset 0x090 clears every output register bit whose data bit is 1 and leaves the others unchanged.
- R6: `pin_oe[n]` equals bit 0 of pin n's configuration word from the clock edge that stores the word.
- R7: `pin_out[n]` is output register bit n when the source code is 0. For a nonzero code k it is `alt_src[k]`, and it follows that input combinationally.
- R8: A read of offset 0x080 returns in bit n the synchronized level of `pin_in[n]` XOR the inversion bit. A level change appears on the third rising edge after it is applied. Bits at or above `NUM_PINS` read 0.
- R9: A read of an offset that is not 8-byte aligned, that lies outside the mapped registers, or that names a pin at or beyond `NUM_PINS` returns 0. A write to such an offset changes no state.
- R10: When a pin's interrupt enable is set, `irq_pend[n]` is high for exactly one cycle, starting at the third rising edge after `pin_in[n]` changes level.
- R11: A change of a pin's inversion bit shows in the input data register one rising edge after the configuration write is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| alt_src | input | 32 | Alternate output signals, indexed by source code (bit 0 unused) |
| pin_out | output | NUM_PINS | Pin output levels |
| pin_oe | output | NUM_PINS | Pin output enables |
| irq_pend | output | NUM_PINS | One-cycle change pulse per interrupt-enabled pin |

## Verification
Register reads are combinational. The bench sets the address half a cycle after an edge and samples one time step later. Configuration, output enable and output register changes are due at the rising edge that takes the write. They are checked at the falling edge after it. A pin level change reaches the input data register and the pending pulse on the third rising edge. The bench therefore samples at the falling edges after the first, second, third and fourth edges: old data and no pulse at the first two, new data with the pulse at the third, and the pulse gone at the fourth. A change of an inversion bit is sampled one falling edge after the write completes.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;

  localparam int unsigned DATA_W    = 64;
  localparam int unsigned SEL_W     = 5;
  localparam int unsigned ALT_W     = 32;
  localparam int unsigned PIN_IDX_W = 5;

  localparam int unsigned OFS_RXDAT = 'h080;
  localparam int unsigned OFS_SET   = 'h088;
  localparam int unsigned OFS_CLR   = 'h090;
  localparam int unsigned OFS_XWIN  = 'h100;
  localparam int unsigned OFS_XEND  = 'h200;

  localparam int unsigned CFG_OE_BIT  = 0;
  localparam int unsigned CFG_INV_BIT = 1;
  localparam int unsigned CFG_IEN_BIT = 2;
  localparam int unsigned CFG_SEL_LSB = 16;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             ien;
    logic             inv;
    logic             oe;
  } pin_cfg_t;

endpackage

// File: rtl/gpio_setclr_rst_sync.sv
module gpio_setclr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;

endmodule

// File: rtl/gpio_setclr_dec.sv
module gpio_setclr_dec
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned NUM_PINS = 20,
  parameter int unsigned EXT_BASE = 16,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 cfg_hit,
  output logic [PIN_IDX_W-1:0] cfg_pin,
  output logic                 rx_hit,
  output logic                 set_hit,
  output logic                 clr_hit
);

  localparam int unsigned PRIM_PINS = (EXT_BASE < NUM_PINS) ? EXT_BASE : NUM_PINS;

  logic [31:0] a32;
  logic [31:0] prim_idx;
  logic [31:0] ext_pin;
  logic        aligned;
  logic        prim_ok;
  logic        ext_ok;

  assign a32 = 32'(addr);

  always_comb begin
    aligned  = (a32[2:0] == 3'd0);
    prim_idx = {28'd0, a32[6:3]};
    ext_pin  = 32'(EXT_BASE) + {27'd0, a32[7:3]};
    prim_ok  = aligned && (a32 < 32'(OFS_RXDAT)) && (prim_idx < 32'(PRIM_PINS));
    ext_ok   = aligned && (a32 >= 32'(OFS_XWIN)) && (a32 < 32'(OFS_XEND)) &&
               (ext_pin < 32'(NUM_PINS));
    cfg_hit  = prim_ok || ext_ok;
    cfg_pin  = ext_ok ? PIN_IDX_W'(ext_pin) : PIN_IDX_W'(prim_idx);
    rx_hit   = (a32 == 32'(OFS_RXDAT));
    set_hit  = (a32 == 32'(OFS_SET));
    clr_hit  = (a32 == 32'(OFS_CLR));
  end

endmodule

// File: rtl/gpio_setclr_pin.sv
module gpio_setclr_pin
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned PIN_ID   = 0,
  parameter int unsigned EXT_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_raw,
  input  logic              cfg_wr,
  input  pin_cfg_t          wr_cfg,
  input  logic              set_bit,
  input  logic              clr_bit,
  input  logic [ALT_W-1:0]  alt_src,
  output logic [DATA_W-1:0] cfg_word,
  output logic              rx_bit,
  output logic              tx_bit,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              irq
);

  localparam bit HAS_IEN = (PIN_ID < EXT_BASE);

  logic             oe_q, oe_d;
  logic             inv_q, inv_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             ien_q;
  logic             tx_q, tx_d, tx_en;
  logic             sync1_q, sync2_q, sync3_q;
  logic             rx_q, rx_d;
  logic             irq_q, irq_d;

  // configuration next state
  always_comb begin
    oe_d  = oe_q;
    inv_d = inv_q;
    sel_d = sel_q;
    if (cfg_wr) begin
      oe_d  = wr_cfg.oe;
      inv_d = wr_cfg.inv;
      sel_d = wr_cfg.sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      inv_q <= 1'b0;
      sel_q <= '0;
    end else begin
      oe_q  <= oe_d;
      inv_q <= inv_d;
      sel_q <= sel_d;
    end
  end

  // interrupt-enable storage exists only below the extended boundary
  generate
    if (HAS_IEN) begin : g_ien
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ien_q <= 1'b0;
        end else if (cfg_wr) begin
          ien_q <= wr_cfg.ien;
        end
      end
    end else begin : g_no_ien
      logic unused_ien;
      assign unused_ien = wr_cfg.ien;
      assign ien_q      = 1'b0;
    end
  endgenerate

  // output register bit: set has priority, the bus never asserts both
  always_comb begin
    tx_en = set_bit | clr_bit;
    tx_d  = set_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= 1'b0;
    end else if (tx_en) begin
      tx_q <= tx_d;
    end
  end

  // input path: two synchronizer flops, one history flop, capture after inversion
  always_comb begin
    rx_d  = sync2_q ^ inv_q;
    irq_d = ien_q & (sync2_q ^ sync3_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      sync3_q <= 1'b0;
      rx_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      sync1_q <= pin_raw;
      sync2_q <= sync1_q;
      sync3_q <= sync2_q;
      rx_q    <= rx_d;
      irq_q   <= irq_d;
    end
  end

  // readback and pad outputs
  always_comb begin
    cfg_word                            = '0;
    cfg_word[CFG_OE_BIT]                = oe_q;
    cfg_word[CFG_INV_BIT]               = inv_q;
    cfg_word[CFG_IEN_BIT]               = ien_q;
    cfg_word[CFG_SEL_LSB +: SEL_W]      = sel_q;
  end

  assign pad_out = (sel_q == '0) ? tx_q : alt_src[sel_q];
  assign pad_oe  = oe_q;
  assign rx_bit  = rx_q;
  assign tx_bit  = tx_q;
  assign irq     = irq_q;

endmodule

// File: rtl/gpio_setclr.sv
module gpio_setclr
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned NUM_PINS = 20,
  parameter int unsigned EXT_BASE = 16,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [63:0]         bus_wdata,
  output logic [63:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [31:0]         alt_src,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] irq_pend
);

  logic                 rst_int_n;
  logic                 cfg_hit, rx_hit, set_hit, clr_hit;
  logic [PIN_IDX_W-1:0] cfg_pin;
  pin_cfg_t             wr_cfg;
  logic                 set_stb, clr_stb;
  logic [NUM_PINS-1:0]  cfg_wr;
  logic [NUM_PINS-1:0]  rx_vec;
  logic [NUM_PINS-1:0]  tx_vec;
  logic [DATA_W-1:0]    cfg_words [NUM_PINS];
  logic [DATA_W-1:0]    rdata_d;
  logic                 unused_wdata;

  gpio_setclr_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  gpio_setclr_dec #(
    .NUM_PINS (NUM_PINS),
    .EXT_BASE (EXT_BASE),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .addr    (bus_addr),
    .cfg_hit (cfg_hit),
    .cfg_pin (cfg_pin),
    .rx_hit  (rx_hit),
    .set_hit (set_hit),
    .clr_hit (clr_hit)
  );

  always_comb begin
    wr_cfg.oe  = bus_wdata[CFG_OE_BIT];
    wr_cfg.inv = bus_wdata[CFG_INV_BIT];
    wr_cfg.ien = bus_wdata[CFG_IEN_BIT];
    wr_cfg.sel = bus_wdata[CFG_SEL_LSB +: SEL_W];
    set_stb    = bus_we & set_hit;
    clr_stb    = bus_we & clr_hit;
  end

  assign unused_wdata = ^bus_wdata;

  generate
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      assign cfg_wr[g] = bus_we && cfg_hit && (cfg_pin == PIN_IDX_W'(g));

      gpio_setclr_pin #(
        .PIN_ID   (g),
        .EXT_BASE (EXT_BASE)
      ) u_pin (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .pin_raw  (pin_in[g]),
        .cfg_wr   (cfg_wr[g]),
        .wr_cfg   (wr_cfg),
        .set_bit  (set_stb & bus_wdata[g]),
        .clr_bit  (clr_stb & bus_wdata[g]),
        .alt_src  (alt_src),
        .cfg_word (cfg_words[g]),
        .rx_bit   (rx_vec[g]),
        .tx_bit   (tx_vec[g]),
        .pad_out  (pin_out[g]),
        .pad_oe   (pin_oe[g]),
        .irq      (irq_pend[g])
      );
    end
  endgenerate

  // read multiplexer
  always_comb begin
    rdata_d = '0;
    if (cfg_hit) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (cfg_pin == PIN_IDX_W'(i)) begin
          rdata_d = rdata_d | cfg_words[i];
        end
      end
    end else if (rx_hit) begin
      rdata_d = DATA_W'(rx_vec);
    end else if (set_hit || clr_hit) begin
      rdata_d = DATA_W'(tx_vec);
    end
  end

  assign bus_rdata = rdata_d;

endmodule

// File: rtl/gpio_setclr_chk.sv
module gpio_setclr_chk #(
  parameter int unsigned NUM_PINS = 20,
  parameter int unsigned EXT_BASE = 16,
  parameter int unsigned ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [NUM_PINS-1:0] wmask,
  input logic [63:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] tx_vec
);

  logic [31:0] a;
  logic        is_set, is_clr, is_vec, mapped;

  always_comb begin
    a      = 32'(bus_addr);
    is_set = (a == 32'h88);
    is_clr = (a == 32'h90);
    is_vec = is_set || is_clr || (a == 32'h80);
    mapped = is_vec;
    if ((a % 8) == 0) begin
      if ((a < 32'h80) && ((a / 8) < EXT_BASE) && ((a / 8) < NUM_PINS)) mapped = 1'b1;
      if ((a >= 32'h100) && (a < 32'h200) && ((EXT_BASE + (a - 32'h100) / 8) < NUM_PINS))
        mapped = 1'b1;
    end
  end

  AST_SET_RAISES_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && is_set) |=> (tx_vec == ($past(tx_vec) | $past(wmask)))); // R4

  AST_CLR_LOWERS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && is_clr) |=> (tx_vec == ($past(tx_vec) & ~$past(wmask)))); // R5

  AST_TX_HELD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we) |=> $stable(tx_vec)); // R9

  AST_OE_MOVES_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != $past(pin_oe)) |-> $past(bus_we)); // R6

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!mapped) |-> (bus_rdata == 64'd0)); // R9

  AST_VECTOR_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    is_vec |-> ((bus_rdata >> NUM_PINS) == 64'd0)); // R8

endmodule

bind gpio_setclr gpio_setclr_chk #(
  .NUM_PINS (NUM_PINS),
  .EXT_BASE (EXT_BASE),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .wmask     (bus_wdata[NUM_PINS-1:0]),
  .bus_rdata (bus_rdata),
  .pin_oe    (pin_oe),
  .tx_vec    (tx_vec)
);

// File: tb/gpio_setclr_bench.sv
module gpio_setclr_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 20;
  localparam int EB = 16;
  localparam int AW = 12;
  localparam logic [NP-1:0] INV_ODD = 20'hAAAAA;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [63:0]   bus_wdata;
  logic [63:0]   bus_rdata;
  logic [NP-1:0] pin_in;
  logic [31:0]   alt_v;
  logic [NP-1:0] pin_out, pin_oe, irq_pend;

  int checks = 0;
  int errors = 0;

  logic [63:0]   m_cfg [NP];
  logic [NP-1:0] m_tx;
  logic [NP-1:0] m_rx;
  logic [NP-1:0] m_inv;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_setclr #(.NUM_PINS(NP), .EXT_BASE(EB), .ADDR_W(AW)) u_gpio_setclr (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .alt_src(alt_v), .pin_out(pin_out), .pin_oe(pin_oe), .irq_pend(irq_pend)
  );

  function automatic logic [AW-1:0] cfg_ofs(int n);
    return (n < EB) ? AW'(8 * n) : AW'(256 + 8 * (n - EB));
  endfunction

  function automatic logic [63:0] keep(int n, logic [63:0] w);
    logic [63:0] k;
    k = w & 64'h001F_0007;
    if (n >= EB) k[2] = 1'b0;
    return k;
  endfunction

  function automatic logic [NP-1:0] exp_out();
    logic [NP-1:0] v;
    for (int n = 0; n < NP; n++) begin
      logic [4:0] s;
      s = m_cfg[n][20:16];
      v[n] = (s == 5'd0) ? m_tx[n] : alt_v[s];
    end
    return v;
  endfunction

  function automatic logic [NP-1:0] exp_oe();
    logic [NP-1:0] v;
    for (int n = 0; n < NP; n++) v[n] = m_cfg[n][0];
    return v;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(logic [AW-1:0] a, logic [63:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [63:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic exp_rd(int a, output bit mapped, output logic [63:0] v);
    mapped = 1'b0; v = '0;
    if (a % 8 == 0) begin
      if (a < 'h80) begin
        if ((a / 8) < EB && (a / 8) < NP) begin mapped = 1'b1; v = m_cfg[a / 8]; end
      end else if (a == 'h80) begin
        mapped = 1'b1; v = 64'(m_rx);
      end else if (a == 'h88 || a == 'h90) begin
        mapped = 1'b1; v = 64'(m_tx);
      end else if (a >= 'h100 && a < 'h200) begin
        if (EB + (a - 'h100) / 8 < NP) begin mapped = 1'b1; v = m_cfg[EB + (a - 'h100) / 8]; end
      end
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [NP-1:0] prev;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0; alt_v = 32'hC3A5_5A3C;
    for (int n = 0; n < NP; n++) m_cfg[n] = '0;
    m_tx = '0; m_rx = '0; m_inv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 pin_oe", 64'(pin_oe), 64'd0);
    chk("R1 pin_out", 64'(pin_out), 64'd0);
    chk("R1 irq_pend", 64'(irq_pend), 64'd0);
    for (int n = 0; n < NP; n++) begin rd(cfg_ofs(n), d); chk("R1 cfg", d, 64'd0); end
    rd(AW'('h88), d); chk("R1 tx", d, 64'd0);
    rd(AW'('h80), d); chk("R1 rx", d, 64'd0);

    // R2 / R3 config map sweep with junk in unused bits
    for (int n = 0; n < NP; n++) begin
      logic [63:0] w;
      w = 64'hFFFF_FFFF_FFE0_FFF8 | (64'((n * 7 + 3) % 32) << 16) | 64'(n % 8);
      wr(cfg_ofs(n), w);
      m_cfg[n] = keep(n, w);
    end
    for (int n = 0; n < NP; n++) begin
      rd(cfg_ofs(n), d);
      if (n >= EB) chk("R3 ext cfg readback", d, m_cfg[n]);
      else         chk("R2 cfg readback", d, m_cfg[n]);
    end
    chk("R6 oe from cfg", 64'(pin_oe), 64'(exp_oe()));
    chk("R7 alternate sources", 64'(pin_out), 64'(exp_out()));

    // R7 select the output register on all pins, output enabled
    for (int n = 0; n < NP; n++) begin wr(cfg_ofs(n), 64'd1); m_cfg[n] = 64'd1; end
    chk("R6 oe all", 64'(pin_oe), 64'(exp_oe()));

    // R4 / R5 set and clear sweep
    for (int i = 0; i < 10; i++) begin
      logic [63:0] m;
      m = 64'(32'h9E37_79B9 * (i + 1)) | ((i % 2) ? 64'hFFFF_FFFF_0000_0000 : 64'd0);
      if (i == 9) m = 64'd0;
      if (i % 3 == 2) begin wr(AW'('h90), m); m_tx = m_tx & ~m[NP-1:0]; end
      else            begin wr(AW'('h88), m); m_tx = m_tx | m[NP-1:0]; end
      rd(AW'('h88), d); chk((i % 3 == 2) ? "R5 clr" : "R4 set", d, 64'(m_tx));
      rd(AW'('h90), d); chk("R4 readback at 0x090", d, 64'(m_tx));
      chk("R7 pins follow tx", 64'(pin_out), 64'(exp_out()));
    end

    // R7 alternate source follows its input
    wr(cfg_ofs(5), 64'h0009_0001); m_cfg[5] = 64'h0009_0001;
    chk("R7 alt select", 64'(pin_out), 64'(exp_out()));
    alt_v = ~alt_v; #1;
    chk("R7 alt follows", 64'(pin_out), 64'(exp_out()));

    // R11 inversion on odd pins, interrupt enable written to all
    for (int n = 0; n < NP; n++) begin
      logic [63:0] w;
      w = 64'd4 | ((n % 2) ? 64'd2 : 64'd0);
      wr(cfg_ofs(n), w); m_cfg[n] = keep(n, w);
    end
    m_inv = INV_ODD;
    @(negedge clk);
    rd(AW'('h80), d); chk("R11 inversion", d, 64'(m_inv));

    // R8 / R10 / R3 input capture latency and change pulses
    prev = '0;
    for (int k = 0; k < 8; k++) begin
      logic [NP-1:0] p;
      p = NP'(k * 32'h2F1B3 + 32'h5A);
      if (k == 6) p = '1;
      if (k == 7) p = '0;
      pin_in = p;
      @(negedge clk);
      chk("R10 no pulse edge1", 64'(irq_pend), 64'd0);
      @(negedge clk);
      rd(AW'('h80), d); chk("R8 old data edge2", d, 64'(prev ^ m_inv));
      chk("R10 no pulse edge2", 64'(irq_pend), 64'd0);
      @(negedge clk);
      rd(AW'('h80), d); chk("R8 new data edge3", d, 64'(p ^ m_inv));
      chk("R10 R3 pulse edge3", 64'(irq_pend), 64'((p ^ prev) & NP'(20'h0FFFF)));
      @(negedge clk);
      chk("R10 pulse ends", 64'(irq_pend), 64'd0);
      prev = p;
    end

    // R11 live inversion change on pin 0
    wr(cfg_ofs(0), 64'd6); m_cfg[0] = 64'd6; m_inv[0] = 1'b1;
    @(negedge clk);
    rd(AW'('h80), d); chk("R11 live inversion", d, 64'(prev ^ m_inv));
    m_rx = prev ^ m_inv;

    // R9 address sweep: unmapped reads zero, unmapped writes ignored
    for (int a = 0; a < 'h400; a += 4) begin
      bit mp; logic [63:0] e;
      exp_rd(a, mp, e);
      rd(AW'(a), d);
      chk(mp ? "R9 mapped read" : "R9 unmapped read", d, e);
      if (!mp) wr(AW'(a), 64'hFFFF_FFFF_FFFF_FFFF);
    end
    for (int a = 0; a < 'h200; a += 8) begin
      bit mp; logic [63:0] e;
      exp_rd(a, mp, e);
      rd(AW'(a), d);
      chk("R9 state after unmapped writes", d, e);
    end
    chk("R9 oe unchanged", 64'(pin_oe), 64'(exp_oe()));
    chk("R9 irq quiet", 64'(irq_pend), 64'd0);

    summary();
    $finish;
  end

endmodule